// File: doc/BRIEF.md
# Serial Control-Port Slave with Busy Handshake

This block is a register-access slave for a serial control bus. It runs entirely on a fast internal clock. The bus clock, select and data input come from outside and are asynchronous to that clock, so they are oversampled. Each transaction carries a 32-bit frame made of an 8-bit command, an 8-bit register index and a 16-bit data word, all sent most significant bit first. A write updates one word of a small register file. A read returns one word on the serial output.

After a write is accepted, the block pulls its ready line `dreq` low for an execution time. That time depends on which register was written and on the value written to it. While `dreq` is low the block ignores every frame that completes, and it reports each such frame with a one-cycle rejection pulse. A bus master uses `dreq` as flow control and waits for it to return high before the next command.

The serial clock must run at no more than one seventh of the internal clock, with high and low phases of at least two internal cycles each.

Top module: `spi_ctl_slave`

## Requirements
- R1: After reset, `dreq` is 1, `sdo` is 0, `frame_rej` is 0, and every register reads as 0x0000.
- R2: A frame is 32 bits, most significant bit first. The layout is command[31:24], register index[23:16], data[15:0]. The input is sampled on the rising `sck` edge, and `sdo` changes only after a falling `sck` edge.
- R3: A write is committed when `cs_n` rises after exactly 32 `sck` rising edges and the command is 0x02. A later read of the same index returns the written word.
- R4: A frame with fewer or more than 32 `sck` rising edges commits nothing and leaves `dreq` high.
- R5: Command 0x03 returns the indexed register on `sdo` during bits 16 to 31, most significant bit first. A read never pulls `dreq` low.
- R6: After a committed write, `dreq` falls no later than 4 internal cycles after `cs_n` rises.
- R7: `dreq` stays low for exactly BUSY_UNIT*(index+1) + data[3:0] internal cycles, then returns high.
- R8: A frame that completes while `dreq` is low does not change any register and does not extend the low time. It produces a one-cycle pulse on `frame_rej`.
- R9: A command other than 0x02 or 0x03 is ignored. A write to an index at or above NUM_REGS is ignored and leaves `dreq` high.
- R10: `sdo` is 0 whenever `cs_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock, at least 7x the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Serial select, active low, asynchronous |
| sck | input | 1 | Serial clock, asynchronous |
| sdi | input | 1 | Serial data into the block |
| sdo | output | 1 | Serial data out of the block; 0 while deselected |
| dreq | output | 1 | Ready; low while a write executes |
| frame_rej | output | 1 | One-cycle pulse when a frame completes while busy |

## Verification
Several properties are checked on every cycle. `dreq` may fall only right after a load of the busy counter, and may rise only when that counter reaches its last count. The register file never changes in a cycle after `dreq` was low. A rejection pulse always follows a busy cycle. `sdo` stays quiet while the select is inactive. Other behaviours can only be shown by the bench's scenarios: exact low times for each index and value, read-back contents, frame-length rejection, and a second write arriving during a long execution.

// File: rtl/spi_ctl_pkg.sv
package spi_ctl_pkg;
  localparam logic [7:0] OP_WRITE   = 8'h02;
  localparam logic [7:0] OP_READ    = 8'h03;
  localparam int         FRAME_BITS = 32;

  typedef struct packed {
    logic [7:0]  op;
    logic [7:0]  idx;
    logic [15:0] data;
  } frame_t;
endpackage

// File: rtl/spi_sync_edge.sv
module spi_sync_edge #(
  parameter int            W       = 3,
  parameter logic [W-1:0]  RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] lvl,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic s1_q, s2_q, s3_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1_q <= RST_VAL[g];
        s2_q <= RST_VAL[g];
        s3_q <= RST_VAL[g];
      end else begin
        s1_q <= async_in[g];
        s2_q <= s1_q;
        s3_q <= s2_q;
      end
    end
    assign lvl[g]  = s2_q;
    assign rise[g] = s2_q & ~s3_q;
    assign fall[g] = ~s2_q & s3_q;
  end
endmodule

// File: rtl/spi_frame.sv
module spi_frame
  import spi_ctl_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cs_act,
  input  logic        cs_end,
  input  logic        sck_rise,
  input  logic        sck_fall,
  input  logic        sdi_s,
  input  logic        busy,
  input  logic [15:0] rd_data,
  output logic [7:0]  rd_idx,
  output logic        frame_done,
  output frame_t      frame,
  output logic        sdo
);
  localparam int CNT_SAT = FRAME_BITS + 1;
  localparam int CW      = $clog2(CNT_SAT + 1);
  localparam logic [CW-1:0] CNT_MAX  = CW'(CNT_SAT);
  localparam logic [CW-1:0] CNT_FULL = CW'(FRAME_BITS);
  localparam logic [CW-1:0] CNT_HDR  = CW'(15);

  logic [CW-1:0] cnt_q, cnt_d;
  logic [31:0]   sr_q, sr_d;
  logic [15:0]   osr_q, osr_d;
  logic          sdo_q, sdo_d;
  logic [15:0]   hdr;

  assign hdr    = {sr_q[14:0], sdi_s};
  assign rd_idx = hdr[7:0];

  always_comb begin
    cnt_d = cnt_q;
    sr_d  = sr_q;
    osr_d = osr_q;
    sdo_d = sdo_q;
    if (!cs_act) begin
      cnt_d = '0;
      osr_d = '0;
      sdo_d = 1'b0;
    end else begin
      if (sck_rise) begin
        sr_d = {sr_q[30:0], sdi_s};
        if (cnt_q != CNT_MAX) cnt_d = cnt_q + 1'b1;
        if (cnt_q == CNT_HDR && hdr[15:8] == OP_READ && !busy) osr_d = rd_data;
      end
      if (sck_fall) begin
        sdo_d = osr_q[15];
        osr_d = {osr_q[14:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sr_q  <= '0;
      osr_q <= '0;
      sdo_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      sr_q  <= sr_d;
      osr_q <= osr_d;
      sdo_q <= sdo_d;
    end
  end

  assign frame_done = cs_end && (cnt_q == CNT_FULL);
  assign frame      = sr_q;
  assign sdo        = sdo_q;

  assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_MAX);
  assert_done_after_active_R3: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> $past(cs_act));
endmodule

// File: rtl/spi_busy_ctr.sv
module spi_busy_ctr #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] load_val,
  output logic             dreq
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (start)            cnt_d = load_val;
    else if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign dreq = (cnt_q == '0);

  assert_fall_after_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dreq) |-> $past(start));
  assert_rise_at_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dreq) |-> ($past(cnt_q) == CNT_W'(1)));
  assert_start_when_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> dreq);
endmodule

// File: rtl/spi_ctl_slave.sv
module spi_ctl_slave
  import spi_ctl_pkg::*;
#(
  parameter int NUM_REGS  = 8,
  parameter int BUSY_UNIT = 4,
  parameter int BUSY_W    = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck,
  input  logic sdi,
  output logic sdo,
  output logic dreq,
  output logic frame_rej
);
  localparam int         IDX_W    = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
  localparam logic [7:0] NUM_REGS_B = 8'(NUM_REGS);

  logic rst_s1_q, rst_n_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_n_i  <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_n_i  <= rst_s1_q;
    end
  end

  logic [2:0] pin_lvl, pin_rise, pin_fall;
  spi_sync_edge #(.W(3), .RST_VAL(3'b001)) u_sync (
    .clk(clk), .rst_n(rst_n_i), .async_in({sdi, sck, cs_n}),
    .lvl(pin_lvl), .rise(pin_rise), .fall(pin_fall)
  );

  logic        frame_done;
  frame_t      frame;
  logic [7:0]  rd_idx;
  logic [15:0] rd_data;
  logic [NUM_REGS-1:0][15:0] regs_q;

  spi_frame u_frame (
    .clk(clk), .rst_n(rst_n_i),
    .cs_act(~pin_lvl[0]), .cs_end(pin_rise[0]),
    .sck_rise(pin_rise[1]), .sck_fall(pin_fall[1]), .sdi_s(pin_lvl[2]),
    .busy(~dreq), .rd_data(rd_data), .rd_idx(rd_idx),
    .frame_done(frame_done), .frame(frame), .sdo(sdo)
  );

  logic              wr_ok, rej_d, rej_q;
  logic [BUSY_W-1:0] busy_val;
  int                busy_int;

  always_comb begin
    rd_data  = (rd_idx < NUM_REGS_B) ? regs_q[rd_idx[IDX_W-1:0]] : 16'h0000;
    wr_ok    = frame_done && dreq && frame.op == OP_WRITE && frame.idx < NUM_REGS_B;
    rej_d    = frame_done && !dreq;
    busy_int = BUSY_UNIT * (int'(frame.idx) + 1) + int'(frame.data[3:0]);
    busy_val = busy_int[BUSY_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      regs_q <= '0;
      rej_q  <= 1'b0;
    end else begin
      rej_q <= rej_d;
      if (wr_ok) regs_q[frame.idx[IDX_W-1:0]] <= frame.data;
    end
  end

  spi_busy_ctr #(.CNT_W(BUSY_W)) u_busy (
    .clk(clk), .rst_n(rst_n_i), .start(wr_ok), .load_val(busy_val), .dreq(dreq)
  );

  assign frame_rej = rej_q;

  assert_no_write_while_busy_R8: assert property (@(posedge clk) disable iff (!rst_n_i)
    !dreq |=> $stable(regs_q));
  assert_rej_follows_busy_R8: assert property (@(posedge clk) disable iff (!rst_n_i)
    frame_rej |-> $past(!dreq));
  assert_sdo_idle_R10: assert property (@(posedge clk) disable iff (!rst_n_i)
    (pin_lvl[0] && $past(pin_lvl[0])) |-> !sdo);
endmodule

// File: tb/tb_spi_ctl_slave.sv
module tb_spi_ctl_slave;
  localparam int UNIT = 64;
  localparam int HALF = 5;

  logic clk = 1'b0;
  logic rst_n, cs_n, sck, sdi;
  logic sdo, dreq, frame_rej;

  always #2 clk = ~clk;

  spi_ctl_slave #(.NUM_REGS(8), .BUSY_UNIT(UNIT), .BUSY_W(10)) dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .sdi(sdi),
    .sdo(sdo), .dreq(dreq), .frame_rej(frame_rej)
  );

  int n_chk = 0, n_fail = 0;
  int cyc = 0, t_fall = 0, t_rise = 0, rej_cnt = 0;
  logic dreq_prev = 1'b1;

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (dreq_prev && !dreq) t_fall = cyc;
    if (!dreq_prev && dreq) t_rise = cyc;
    dreq_prev = dreq;
    if (frame_rej) rej_cnt = rej_cnt + 1;
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic xfer(input logic [31:0] word, input int nbits, output logic [15:0] rd);
    rd = '0;
    @(negedge clk); cs_n = 1'b0; sck = 1'b0;
    for (int i = 0; i < nbits; i++) begin
      sdi = (i < 32) ? word[31-i] : 1'b0;
      repeat (HALF) @(negedge clk);
      if (i >= 16 && i < 32) rd[31-i] = sdo;
      sck = 1'b1;
      repeat (HALF) @(negedge clk);
      sck = 1'b0;
    end
    repeat (HALF) @(negedge clk);
    cs_n = 1'b1;
  endtask

  task automatic no_busy(input string tag);
    logic seen_low = 1'b0;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      if (!dreq) seen_low = 1'b1;
    end
    check(!seen_low, tag, {31'd0, seen_low}, 32'd0);
  endtask

  task automatic wait_high();
    for (int k = 0; k < 3000; k++) begin
      @(negedge clk);
      if (dreq) break;
    end
    @(negedge clk);
  endtask

  task automatic write_meas(input logic [7:0] idx, input logic [15:0] data);
    logic [15:0] rd;
    int lat = 99;
    int expn = UNIT * (int'(idx) + 1) + int'(data[3:0]);
    xfer({8'h02, idx, data}, 32, rd);
    for (int k = 1; k <= 6; k++) begin
      @(negedge clk);
      if (!dreq) begin lat = k; break; end
    end
    check(lat <= 4, "R6 dreq fall latency", lat, 4);
    wait_high();
    check(t_rise - t_fall == expn, "R7 dreq low length", t_rise - t_fall, expn);
  endtask

  task automatic read_chk(input logic [7:0] idx, input logic [15:0] exp, input string tag);
    logic [15:0] rd;
    xfer({8'h03, idx, 16'h0000}, 32, rd);
    check(rd == exp, tag, {16'd0, rd}, {16'd0, exp});
    check(sdo == 1'b0, "R10 sdo idle after deselect", {31'd0, sdo}, 32'd0);
  endtask

  localparam logic [31:0] VEC [7] = '{
    {8'h02, 8'h00, 16'h1234},
    {8'h02, 8'h05, 16'hBEEF},
    {8'h02, 8'h07, 16'h0009},
    {8'h03, 8'h00, 16'h1234},
    {8'h03, 8'h05, 16'hBEEF},
    {8'h03, 8'h07, 16'h0009},
    {8'h03, 8'h03, 16'h0000}
  };

  initial begin
    repeat (100000) @(negedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] rd;
    rst_n = 1'b0; cs_n = 1'b1; sck = 1'b0; sdi = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    // R1 reset state
    check(dreq == 1'b1, "R1 dreq after reset", {31'd0, dreq}, 32'd1);
    check(sdo == 1'b0, "R1 sdo after reset", {31'd0, sdo}, 32'd0);
    check(frame_rej == 1'b0, "R1 frame_rej after reset", {31'd0, frame_rej}, 32'd0);
    read_chk(8'h04, 16'h0000, "R1 register reset value");

    // table walk: writes R3 R6 R7, reads R2 R5
    for (int k = 0; k < 7; k++) begin
      if (VEC[k][31:24] == 8'h02) write_meas(VEC[k][23:16], VEC[k][15:0]);
      else begin
        read_chk(VEC[k][23:16], VEC[k][15:0], "R2 R3 R5 read-back data");
        no_busy("R5 read leaves dreq high");
      end
    end

    // R4 short and long frames
    xfer({8'h02, 8'h01, 16'hAAAA}, 20, rd);
    no_busy("R4 short frame no busy");
    xfer({8'h02, 8'h01, 16'h5555}, 33, rd);
    no_busy("R4 long frame no busy");
    read_chk(8'h01, 16'h0000, "R4 truncated or overlong frame not committed");

    // R9 unknown command and out-of-range index
    xfer({8'h05, 8'h02, 16'h7777}, 32, rd);
    no_busy("R9 unknown command no busy");
    read_chk(8'h02, 16'h0000, "R9 unknown command no write");
    xfer({8'h02, 8'h20, 16'h4321}, 32, rd);
    no_busy("R9 out-of-range index no busy");

    // R8 write during execution
    check(rej_cnt == 0, "R8 no rejection before busy write", rej_cnt, 0);
    xfer({8'h02, 8'h07, 16'h0003}, 32, rd);
    xfer({8'h02, 8'h07, 16'h0005}, 32, rd);
    repeat (4) @(negedge clk);
    check(rej_cnt == 1, "R8 rejection pulse count", rej_cnt, 1);
    wait_high();
    check(t_rise - t_fall == UNIT * 8 + 3, "R8 busy not extended", t_rise - t_fall, UNIT * 8 + 3);
    read_chk(8'h07, 16'h0003, "R8 rejected write not committed");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule